// File: doc/BRIEF.md
# Reset and Watchdog Supervisor

This block produces the active-low reset for a processor. The reset is held while a monitored supply is reported below its threshold. Once the supply is good, the reset is held for a fixed release delay and then let go. After release, an optional watchdog expects the processor to toggle a kick line. A long enough silence produces a full reset pulse, and the watchdog is armed again when that pulse ends. The pulses therefore repeat until kicks resume, the supply drops, or the watchdog is switched off.

All timing counts a one-millisecond `tick` strobe rather than raw clocks. The defaults are a 200-tick release delay and a 1600-tick watchdog window. The block also registers a power-fail comparator flag onto a separate active-low output. The analog comparators sit outside the block, so `vmOk` and `pfiOk` arrive already digital and synchronous to `clk`. The kick line is asynchronous and is synchronized inside the block.

Top module: `wdog_supervisor`

## Requirements
- R1: At any clock edge where `vmOk` is 0, `rstN` is 0 after that edge and stays 0 while `vmOk` stays 0.
- R2: If `vmOk` goes to 1 and stays there, `rstN` is 0 for the first edge plus the next RESET_TICKS edges that carry a tick. It becomes 1 after the edge that counts the last of those ticks.
- R3: Both timers advance only on clock edges where `tick` is 1. With `tick` held at 0 the reset is never released and no timeout occurs.
- R4: While `wdEn` is 0, a released reset never drops unless `vmOk` drops. Lowering `wdEn` for one clock clears the watchdog count, so a new full window of WDOG_TICKS ticks is needed afterwards.
- R5: Every change of `wdKick`, rising or falling, restarts the watchdog window. The change passes through a two-flop synchronizer and an edge register, so it acts on the third rising clock edge after the change. With one tick per clock, kicks spaced at most WDOG_TICKS clocks apart keep `rstN` at 1.
- R6: The watchdog is armed only while reset is released. After WDOG_TICKS ticks with `wdEn` at 1 and no kick, `rstN` goes to 0 for RESET_TICKS ticks and then returns to 1 with a fresh window. This repeats while no kick arrives.
- R7: A drop of `vmOk` forces `rstN` to 0 after the next edge, whatever the current phase. It discards any partial delay or watchdog count, so the next release needs the full delay again.
- R8: `pfoN` equals the value `pfiOk` had at the previous clock edge (0 = power fail), independent of all other inputs.
- R9: While `arstN` is 0, `rstN` and `pfoN` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arstN | input | 1 | Asynchronous active-low reset of the block |
| tick | input | 1 | One-cycle strobe every millisecond |
| vmOk | input | 1 | 1 when the monitored supply is above threshold |
| pfiOk | input | 1 | 1 when the power-fail input is above threshold |
| wdEn | input | 1 | 1 when the kick pin is driven; 0 when it floats |
| wdKick | input | 1 | Asynchronous watchdog kick level |
| rstN | output | 1 | Active-low processor reset |
| pfoN | output | 1 | Active-low power-fail flag |

## Verification
The bench builds the block with RESET_TICKS = 4 and WDOG_TICKS = 8. At these values the exact release edge, the exact timeout edge and several periodic timeout pulses all fall within a few dozen clocks. A table of kick gaps runs from 1 clock to past the window, so the last safe gap (equal to WDOG_TICKS) and the first failing gap are both hit. Ticks are driven on every clock for exact edge checks. They are then stopped and divided by three to show that only ticks move the timers.

// File: rtl/wdog_supervisor_pkg.sv
package wdog_supervisor_pkg;
  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_DELAY = 2'd1,
    ST_RUN   = 2'd2
  } supvState_e;

  // strobes from control to the shared tick counter
  typedef struct packed {
    logic clrCnt;
    logic incCnt;
  } cntStrobe_t;
endpackage

// File: rtl/wdog_supervisor_dpath.sv
module wdog_supervisor_dpath
  import wdog_supervisor_pkg::*;
#(
  parameter int RESET_TICKS = 200,
  parameter int WDOG_TICKS  = 1600,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       arstN,
  input  logic       kickIn,
  input  logic       pfiOk,
  input  cntStrobe_t stb,
  output logic       kickEdge,
  output logic       delayHit,
  output logic       wdHit,
  output logic       pfoN
);
  localparam int CNT_MAX = (RESET_TICKS > WDOG_TICKS) ? RESET_TICKS : WDOG_TICKS;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0]     cnt;
  logic [SYNC_STAGES:0] kickQ;  // synchronizer stages plus one edge register

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) kickQ <= '0;
    else        kickQ <= {kickQ[SYNC_STAGES-1:0], kickIn};
  end

  assign kickEdge = kickQ[SYNC_STAGES] ^ kickQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN)          cnt <= '0;
    else if (stb.clrCnt) cnt <= '0;
    else if (stb.incCnt) cnt <= cnt + 1'b1;
  end

  assign delayHit = (cnt == CNT_W'(RESET_TICKS - 1));
  assign wdHit    = (cnt == CNT_W'(WDOG_TICKS - 1));

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) pfoN <= 1'b0;
    else        pfoN <= pfiOk;
  end
endmodule

// File: rtl/wdog_supervisor_ctrl.sv
module wdog_supervisor_ctrl
  import wdog_supervisor_pkg::*;
(
  input  logic       clk,
  input  logic       arstN,
  input  logic       tick,
  input  logic       vmOk,
  input  logic       wdEn,
  input  logic       kickEdge,
  input  logic       delayHit,
  input  logic       wdHit,
  output cntStrobe_t stb,
  output logic       rstN
);
  supvState_e state, nxtState;

  always_comb begin
    nxtState = state;
    stb      = '0;
    unique case (state)
      ST_HOLD: begin
        stb.clrCnt = 1'b1;
        if (vmOk) nxtState = ST_DELAY;
      end
      ST_DELAY: begin
        if (tick) begin
          if (delayHit) begin
            nxtState   = ST_RUN;
            stb.clrCnt = 1'b1;
          end else begin
            stb.incCnt = 1'b1;
          end
        end
      end
      ST_RUN: begin
        if (!wdEn || kickEdge) begin
          stb.clrCnt = 1'b1;
        end else if (tick) begin
          if (wdHit) begin
            nxtState   = ST_DELAY;
            stb.clrCnt = 1'b1;
          end else begin
            stb.incCnt = 1'b1;
          end
        end
      end
      default: begin
        nxtState   = ST_HOLD;
        stb.clrCnt = 1'b1;
      end
    endcase
    if (!vmOk) begin
      nxtState   = ST_HOLD;
      stb.clrCnt = 1'b1;
      stb.incCnt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      state <= ST_HOLD;
      rstN  <= 1'b0;
    end else begin
      state <= nxtState;
      rstN  <= (nxtState == ST_RUN);
    end
  end
endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor
  import wdog_supervisor_pkg::*;
#(
  parameter int RESET_TICKS = 200,
  parameter int WDOG_TICKS  = 1600
) (
  input  logic clk,
  input  logic arstN,
  input  logic tick,
  input  logic vmOk,
  input  logic pfiOk,
  input  logic wdEn,
  input  logic wdKick,
  output logic rstN,
  output logic pfoN
);
  cntStrobe_t stb;
  logic       kickEdge;
  logic       delayHit;
  logic       wdHit;

  wdog_supervisor_ctrl u_ctrl (
    .clk(clk), .arstN(arstN), .tick(tick), .vmOk(vmOk), .wdEn(wdEn),
    .kickEdge(kickEdge), .delayHit(delayHit), .wdHit(wdHit),
    .stb(stb), .rstN(rstN)
  );

  wdog_supervisor_dpath #(
    .RESET_TICKS(RESET_TICKS), .WDOG_TICKS(WDOG_TICKS), .SYNC_STAGES(2)
  ) u_dpath (
    .clk(clk), .arstN(arstN), .kickIn(wdKick), .pfiOk(pfiOk), .stb(stb),
    .kickEdge(kickEdge), .delayHit(delayHit), .wdHit(wdHit), .pfoN(pfoN)
  );
endmodule

// File: rtl/wdog_supervisor_chk.sv
module wdog_supervisor_chk (
  input logic clk,
  input logic arstN,
  input logic vmOk,
  input logic pfiOk,
  input logic wdEn,
  input logic kickEdge,
  input logic rstN,
  input logic pfoN
);
  AST_VM_LOW_HOLDS: assert property (@(posedge clk) disable iff (!arstN)
    !vmOk |=> !rstN);  // R1

  AST_RELEASE_NEEDS_VM: assert property (@(posedge clk) disable iff (!arstN)
    $rose(rstN) |-> $past(vmOk));  // R2

  AST_NO_DROP_DISABLED: assert property (@(posedge clk) disable iff (!arstN)
    (rstN && vmOk && !wdEn) |=> rstN);  // R4

  AST_KICK_KEEPS: assert property (@(posedge clk) disable iff (!arstN)
    (rstN && vmOk && kickEdge) |=> rstN);  // R5

  AST_PFO_FOLLOWS: assert property (@(posedge clk) disable iff (!arstN)
    1'b1 |=> (pfoN == $past(pfiOk)));  // R8
endmodule

bind wdog_supervisor wdog_supervisor_chk u_chk (
  .clk(clk), .arstN(arstN), .vmOk(vmOk), .pfiOk(pfiOk), .wdEn(wdEn),
  .kickEdge(kickEdge), .rstN(rstN), .pfoN(pfoN)
);

// File: tb/wdog_supervisor_bench.sv
`timescale 1ns/1ps
module wdog_supervisor_bench;
  localparam int RT = 4;
  localparam int WT = 8;
  localparam int NGAP = 8;
  // kick gap in clocks; a pulse is expected when gap exceeds WT
  localparam int GAPS [NGAP] = '{1, 2, 5, 7, 8, 9, 12, 3};

  logic clk = 1'b0;
  logic arstN = 1'b0;
  logic tick = 1'b1;
  logic vmOk = 1'b0, pfiOk = 1'b0, wdEn = 1'b0, wdKick = 1'b0;
  logic rstN, pfoN;

  int checks = 0, fails = 0;
  int tickDiv = 1, divCnt = 0;
  logic tickOff = 1'b0;
  logic watching = 1'b0, sawLow = 1'b0;
  bit done = 1'b0;

  wdog_supervisor #(.RESET_TICKS(RT), .WDOG_TICKS(WT)) u_wdog_supervisor (
    .clk(clk), .arstN(arstN), .tick(tick), .vmOk(vmOk), .pfiOk(pfiOk),
    .wdEn(wdEn), .wdKick(wdKick), .rstN(rstN), .pfoN(pfoN)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    tick   <= !tickOff && (divCnt == 0);
    divCnt <= (divCnt + 1 >= tickDiv) ? 0 : divCnt + 1;
    if (watching && !rstN) sawLow <= 1'b1;
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    wait_neg(3);
    chk("R9 rstN in reset", rstN, 1'b0);
    chk("R9 pfoN in reset", pfoN, 1'b0);
    arstN = 1'b1;
    pfiOk = 1'b1;
    wait_neg(20);
    chk("R1 held while vmOk low", rstN, 1'b0);
    chk("R8 pfoN follows pfiOk", pfoN, 1'b1);

    // R2 exact release edge
    vmOk = 1'b1;
    wait_neg(RT);
    chk("R2 still low before delay ends", rstN, 1'b0);
    wait_neg(1);
    chk("R2 released after delay", rstN, 1'b1);

    // R4 watchdog disabled: no timeout
    wait_neg(3 * WT);
    chk("R4 no timeout when disabled", rstN, 1'b1);

    // R6 timeout and periodic repeat
    wdEn = 1'b1;
    wait_neg(WT - 1);
    chk("R6 high just before timeout", rstN, 1'b1);
    wait_neg(1);
    chk("R6 low at timeout", rstN, 1'b0);
    wait_neg(RT - 1);
    chk("R6 pulse lasts full delay", rstN, 1'b0);
    wait_neg(1);
    chk("R6 re-released after pulse", rstN, 1'b1);
    wait_neg(WT - 1);
    chk("R6 high before second timeout", rstN, 1'b1);
    wait_neg(1);
    chk("R6 second timeout repeats", rstN, 1'b0);
    wdEn = 1'b0;
    wait_neg(RT + 1);
    chk("R4 disable keeps voltage reset path", rstN, 1'b1);

    // R4 disabling clears count
    wdEn = 1'b1;
    wait_neg(WT - 1);
    wdEn = 1'b0;
    wait_neg(1);
    wdEn = 1'b1;
    wait_neg(WT - 1);
    chk("R4 disable cleared watchdog count", rstN, 1'b1);
    wdEn = 1'b0;
    wait_neg(1);

    // R5/R6 table of kick gaps, both edge polarities alternate
    wdEn = 1'b1;
    for (int e = 0; e < NGAP; e++) begin
      sawLow = 1'b0;
      watching = 1'b1;
      wdKick = ~wdKick;
      wait_neg(GAPS[e]);
      wdKick = ~wdKick;
      wait_neg(3);
      watching = 1'b0;
      chk((GAPS[e] > WT) ? "R6 gap too long times out" : "R5 kick gap keeps reset high",
          sawLow, logic'(GAPS[e] > WT));
      while (!rstN) @(negedge clk);
    end

    // R7 vmOk drop cancels run and delay
    vmOk = 1'b0;
    wait_neg(1);
    chk("R7 vmOk drop forces reset", rstN, 1'b0);
    vmOk = 1'b1;
    wait_neg(3);
    vmOk = 1'b0;
    wait_neg(1);
    vmOk = 1'b1;
    wait_neg(RT);
    chk("R7 partial delay discarded", rstN, 1'b0);
    wait_neg(1);
    chk("R7 full delay then release", rstN, 1'b1);
    wdEn = 1'b0;

    // R3 ticks gate the timers
    vmOk = 1'b0;
    wait_neg(1);
    tickOff = 1'b1;
    vmOk = 1'b1;
    wait_neg(50);
    chk("R3 no release without ticks", rstN, 1'b0);
    tickDiv = 3;
    tickOff = 1'b0;
    wait_neg(6);
    chk("R3 divided ticks slow release", rstN, 1'b0);
    wait_neg(14);
    chk("R3 release after enough ticks", rstN, 1'b1);

    // R8 power-fail flag independent of vmOk
    pfiOk = 1'b0;
    wait_neg(1);
    chk("R8 pfoN low on power fail", pfoN, 1'b0);
    vmOk = 1'b0;
    pfiOk = 1'b1;
    wait_neg(1);
    chk("R8 pfoN high with vmOk low", pfoN, 1'b1);
    chk("R1 reset with vmOk low", rstN, 1'b0);

    finish_run();
  end
endmodule